// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is the host-side master for a serial-output analog-to-digital converter. A start request pulls chip select low. The block then divides the system clock into a serial clock and collects the converter's output bits. When the frame ends it releases chip select and presents the extracted sample with a one-cycle valid strobe. The serial clock idles high. Every edge is timed by a programmable half-period divider.

Each frame opens with two leading zeros. The data bits follow, most significant first, and trailing zeros close the frame. The converter drives the first leading zero when chip select falls and moves to the next bit on each serial clock falling edge. Capture can be configured for falling or rising edges. Falling-edge capture sees every bit from the first leading zero onward. Rising-edge capture sees the second leading zero first and never sees the first one.

A frame is either 16 or 14 serial clocks long. Resolution is 12 or 10 bits. After a frame, a programmable quiet time must pass before the next start is accepted. Busy covers the whole span from the accepted start to the end of the quiet time.

Top module: `serial_adc_reader`

## Requirements
- R1: After reset, cs_n and sclk are high, and busy, data_valid and lead_err are low.
- R2: A start seen while busy is low pulls cs_n low and raises busy on the same clock edge.
- R3: Each serial clock half period lasts `half_div` system clocks (a value of 0 acts as 1). The first sclk fall comes `half_div` clocks after cs_n falls. sclk is always high while cs_n is high.
- R4: A frame contains exactly 16 sclk falling edges when `cfg_short`=0, or exactly 14 when `cfg_short`=1. cs_n rises together with the sclk rise that follows the last fall.
- R5: With `cfg_rise`=0, the k-th sclk fall samples frame bit k-1, where bit 0 is the bit present when cs_n falls. The result is formed from frame bits 2 and up, most significant first.
- R6: With `cfg_rise`=1, the k-th sclk rise samples frame bit k. Frame bit 0 is never sampled. Data still comes from frame bits 2 and up.
- R7: With `cfg_res10`=1, the result is 10 bits wide and sits in data_out[9:0], with data_out[11:10] at zero. With `cfg_res10`=0, the result is 12 bits and fills data_out[11:0]. Any bit after the data field is ignored.
- R8: lead_err is 1 with the result if a sampled leading bit was 1. In falling mode the sampled leading bits are frame bits 0 and 1; in rising mode only frame bit 1 is sampled.
- R9: data_valid is high for exactly one clock, on the same edge where cs_n rises. data_out and lead_err are valid in that cycle.
- R10: busy stays high for `quiet_len`+1 clocks after cs_n rises. A start while busy is high is ignored.
- R11: The three mode inputs are latched when a start is accepted. Changing them mid-frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame request |
| cfg_short | input | 1 | 1 selects the 14-clock frame |
| cfg_res10 | input | 1 | 1 selects 10-bit resolution |
| cfg_rise | input | 1 | 1 selects rising-edge capture |
| half_div | input | DIV_W | System clocks per sclk half period |
| quiet_len | input | QUIET_W | Quiet clocks after a frame |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| busy | output | 1 | Frame or quiet time in progress |
| data_out | output | DATA_W | Extracted sample |
| data_valid | output | 1 | One-cycle result strobe |
| lead_err | output | 1 | Leading-zero violation |

## Verification
The bench uses the default widths (DIV_W=4, QUIET_W=8, DATA_W=12). It runs with a half period of 3 and a quiet length of 5, then with a half period of 1 and a quiet length of 0. The half period of 3 lets the bench count individual clock phases and separate the sclk edges from cs_n. The half-period-1 and zero-quiet runs reach the smallest divider value and the shortest busy tail. A quiet length of 20 leaves room to insert a start request during the quiet time.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  localparam int LEAD_BITS = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_QUIET} sar_state_e;

  // number of sclk falling edges in one frame
  function automatic logic [4:0] frame_edges(input logic short_frame);
    return short_frame ? 5'd14 : 5'd16;
  endfunction

  function automatic logic [4:0] res_bits(input logic res10);
    return res10 ? 5'd10 : 5'd12;
  endfunction

  // frame bit index lies in the data field
  function automatic logic in_data(input logic [4:0] idx, input logic res10);
    return (idx >= 5'(LEAD_BITS)) && (idx < res_bits(res10) + 5'(LEAD_BITS));
  endfunction
endpackage

// File: rtl/sar_clkdiv.sv
`timescale 1ns/1ps
module sar_clkdiv #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_len,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last = (half_len == '0) ? '0 : half_len - DIV_W'(1);
  assign tick = run && (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/sar_capture.sv
`timescale 1ns/1ps
module sar_capture
  import sar_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic [4:0]        idx,
  input  logic              res10,
  input  logic              sdata,
  output logic [DATA_W-1:0] word,
  output logic              lead_err
);
  logic take_data;
  logic take_lead;

  assign take_data = sample && in_data(idx, res10);
  assign take_lead = sample && (idx < 5'(LEAD_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word     <= '0;
      lead_err <= 1'b0;
    end else if (clear) begin
      word     <= '0;
      lead_err <= 1'b0;
    end else begin
      if (take_data) word <= {word[DATA_W-2:0], sdata};
      if (take_lead && sdata) lead_err <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_adc_reader.sv
`timescale 1ns/1ps
module serial_adc_reader
  import sar_pkg::*;
#(
  parameter int DIV_W   = 4,
  parameter int QUIET_W = 8,
  parameter int DATA_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               cfg_short,
  input  logic               cfg_res10,
  input  logic               cfg_rise,
  input  logic [DIV_W-1:0]   half_div,
  input  logic [QUIET_W-1:0] quiet_len,
  input  logic               sdata,
  output logic               cs_n,
  output logic               sclk,
  output logic               busy,
  output logic [DATA_W-1:0]  data_out,
  output logic               data_valid,
  output logic               lead_err
);
  sar_state_e         state;
  logic               m_short, m_res10, m_rise;
  logic [4:0]         fall_cnt;
  logic [QUIET_W-1:0] quiet_cnt;
  logic [DATA_W-1:0]  cap_word;
  logic               cap_err;

  // named internal events
  logic accept, tick, fall_evt, rise_evt, frame_end, sample;

  assign accept    = (state == ST_IDLE) && start;
  assign fall_evt  = (state == ST_FRAME) && tick && sclk;
  assign rise_evt  = (state == ST_FRAME) && tick && !sclk;
  assign frame_end = rise_evt && (fall_cnt == frame_edges(m_short));
  assign sample    = m_rise ? (rise_evt && !frame_end) : fall_evt;

  sar_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (state == ST_FRAME),
    .half_len (half_div),
    .tick     (tick)
  );

  sar_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .sample   (sample),
    .idx      (fall_cnt),
    .res10    (m_res10),
    .sdata    (sdata),
    .word     (cap_word),
    .lead_err (cap_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      m_short    <= 1'b0;
      m_res10    <= 1'b0;
      m_rise     <= 1'b0;
      fall_cnt   <= '0;
      quiet_cnt  <= '0;
      cs_n       <= 1'b1;
      sclk       <= 1'b1;
      data_out   <= '0;
      data_valid <= 1'b0;
      lead_err   <= 1'b0;
    end else begin
      data_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_FRAME;
          m_short  <= cfg_short;
          m_res10  <= cfg_res10;
          m_rise   <= cfg_rise;
          fall_cnt <= '0;
          cs_n     <= 1'b0;
        end
        ST_FRAME: begin
          if (fall_evt) begin
            sclk     <= 1'b0;
            fall_cnt <= fall_cnt + 5'd1;
          end else if (rise_evt) begin
            sclk <= 1'b1;
            if (frame_end) begin
              cs_n       <= 1'b1;
              state      <= ST_QUIET;
              quiet_cnt  <= quiet_len;
              data_out   <= cap_word;
              lead_err   <= cap_err;
              data_valid <= 1'b1;
            end
          end
        end
        ST_QUIET: begin
          if (quiet_cnt == '0) state <= ST_IDLE;
          else                 quiet_cnt <= quiet_cnt - QUIET_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/sar_checker.sv
`timescale 1ns/1ps
module sar_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic cs_n,
  input logic sclk,
  input logic data_valid
);
  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (!cs_n && busy));
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);
  assert_valid_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (cs_n && !$past(cs_n)));
  assert_no_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !$past(busy));
  assert_busy_covers_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
endmodule

bind serial_adc_reader sar_checker u_sar_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .cs_n       (cs_n),
  .sclk       (sclk),
  .data_valid (data_valid)
);

// File: tb/test_serial_adc_reader.sv
`timescale 1ns/1ps
module test_serial_adc_reader;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic        cfg_short = 1'b0, cfg_res10 = 1'b0, cfg_rise = 1'b0;
  logic [3:0]  half_div = 4'd3;
  logic [7:0]  quiet_len = 8'd5;
  logic        sdata;
  logic        cs_n, sclk, busy, data_valid, lead_err;
  logic [11:0] data_out;

  int checks = 0, errors = 0, falls = 0, ptr = 0;
  logic fb [16];
  bit done = 0;

  always #4 clk = ~clk;

  serial_adc_reader i_serial_adc_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_short(cfg_short),
    .cfg_res10(cfg_res10), .cfg_rise(cfg_rise), .half_div(half_div),
    .quiet_len(quiet_len), .sdata(sdata), .cs_n(cs_n), .sclk(sclk),
    .busy(busy), .data_out(data_out), .data_valid(data_valid), .lead_err(lead_err)
  );

  // converter model: bit 0 on cs_n fall, next bit after each sclk fall
  assign sdata = fb[ptr > 15 ? 15 : ptr];
  always @(negedge cs_n) begin ptr = 0; falls = 0; end
  always @(negedge sclk) if (!cs_n) begin falls++; #1 ptr++; end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // [19] short [18] res10 [17] rise [16] frame bit0 [15] frame bit1 [11:0] word
  localparam logic [19:0] VEC [8] = '{
    {3'b000, 2'b00, 3'b0, 12'hA5C},
    {3'b001, 2'b00, 3'b0, 12'h3F1},
    {3'b100, 2'b00, 3'b0, 12'hFFF},
    {3'b111, 2'b00, 3'b0, 12'h2AA},
    {3'b010, 2'b00, 3'b0, 12'h155},
    {3'b000, 2'b10, 3'b0, 12'h800},
    {3'b001, 2'b10, 3'b0, 12'h001},
    {3'b101, 2'b01, 3'b0, 12'h7E0}
  };

  task automatic run_frame(input logic [19:0] v, input bit flip, input bit poke);
    int n, r;
    logic [11:0] expd;
    logic experr;
    string md;
    cfg_short = v[19]; cfg_res10 = v[18]; cfg_rise = v[17];
    md = v[17] ? "R6" : "R5";
    r = v[18] ? 10 : 12;
    for (int i = 0; i < 16; i++)
      fb[i] = (i == 0) ? v[16] : (i == 1) ? v[15] : (i < 2 + r) ? v[r + 1 - i] : 1'b1;
    expd   = v[18] ? {2'b00, v[9:0]} : v[11:0];
    experr = v[17] ? v[15] : (v[16] | v[15]);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!cs_n && busy, "R2 cs_n/busy after start", {cs_n, busy}, 2'b01);
    if (flip) begin cfg_short = ~cfg_short; cfg_res10 = ~cfg_res10; end
    n = 0;
    while (sclk) begin @(negedge clk); n++; end
    chk(n == int'(half_div == 0 ? 1 : half_div), "R3 first fall delay", n, half_div);
    n = 0;
    while (!sclk) begin @(negedge clk); n++; end
    chk(n == int'(half_div == 0 ? 1 : half_div), "R3 low phase", n, half_div);
    while (!data_valid) @(negedge clk);
    chk(data_out == expd, v[18] ? "R7 10-bit result" : md, data_out, expd);
    chk(lead_err == experr, "R8 lead_err", lead_err, experr);
    chk(falls == (v[19] ? 14 : 16), "R4 falling edge count", falls, v[19] ? 14 : 16);
    chk(cs_n, "R9 cs_n high with valid", cs_n, 1);
    @(negedge clk);
    chk(!data_valid, "R9 valid width", data_valid, 0);
    if (poke) begin
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      n = 2;
      while (busy) begin
        chk(cs_n, "R10 start ignored while busy", cs_n, 1);
        @(negedge clk); n++;
      end
      @(negedge clk);
      chk(cs_n && !busy, "R10 no frame from ignored start", {cs_n, busy}, 2'b10);
    end else begin
      n = 1;
      while (busy) begin @(negedge clk); n++; end
      chk(n == int'(quiet_len) + 1, "R10 busy tail", n, quiet_len + 1);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) fb[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n && sclk && !busy && !data_valid && !lead_err, "R1 reset state",
        {cs_n, sclk, busy, data_valid, lead_err}, 5'b11000);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 8; k++) run_frame(VEC[k], 1'b0, 1'b0);
    // R11: mode flipped mid-frame, frame follows latched 16-clock 12-bit mode
    run_frame({3'b000, 2'b00, 3'b0, 12'hC3A}, 1'b1, 1'b0);
    // smallest divider and no quiet time
    half_div = 4'd1; quiet_len = 8'd0;
    run_frame({3'b000, 2'b00, 3'b0, 12'h5A6}, 1'b0, 1'b0);
    run_frame({3'b101, 2'b00, 3'b0, 12'h9C3}, 1'b0, 1'b0);
    // divider value 0 acts as 1
    half_div = 4'd0;
    run_frame({3'b010, 2'b00, 3'b0, 12'h0F0}, 1'b0, 1'b0);
    // start during quiet time
    half_div = 4'd3; quiet_len = 8'd20;
    run_frame({3'b000, 2'b00, 3'b0, 12'h123}, 1'b0, 1'b1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule